// File: doc/BRIEF.md
# Split-Stage Pipeline Hazard Unit

This block resolves data hazards for a seven-stage in-order pipeline in which both the execute phase and the memory phase take two stages each. The stages are IF, ID, EX1, EX2, MEM1, MEM2 and WB. Results cannot be picked up inside either split pair. An ALU result can first be taken from the latch between EX2 and MEM1. A loaded value can first be taken from the latch between MEM2 and WB.

The surrounding pipeline presents the register fields of the instructions that currently sit in each stage. An empty stage presents zeros. The unit is purely combinational and returns four results in the same cycle:
- a stall that freezes IF and ID and places a bubble into EX1;
- two forwarding selects for the operands that enter EX1;
- a late select that replaces store data in MEM1 with the value in the MEM2/WB latch.

A producer that is in WB needs no help, because the register file writes before it reads.

Top module: `hazard_split7`

## Requirements
- R1: Stall is 1 while the instruction in ID reads a nonzero register that the instruction in EX1 writes. For an ALU producer, this gives exactly one bubble before a dependent instruction that follows directly.
- R2: When a load feeds a following instruction's ordinary operand, the bubble count depends on the distance between them: 3 for an adjacent consumer, 2 at distance two, 1 at distance three and 0 at distance four.
- R3: The encoding of fwd_a and fwd_b is 0 for the register-file value, 1 for the EX2/MEM1 latch, 2 for the MEM1/MEM2 latch and 3 for the MEM2/WB latch. Codes 1 and 2 are given only for non-load producers in MEM1 and MEM2 respectively. Code 3 is given for any writer in WB.
- R4: When several older writers match an EX1 source, the select follows the youngest one. If that youngest writer is a load still in MEM1 or MEM2, the select is 0.
- R5: Register 0 never produces a stall and never produces a nonzero select.
- R6: st_fwd is 1 when a store in MEM1 has a nonzero data register, the WB instruction writes that register, and no instruction in MEM2 writes it.
- R7: A store whose data register comes from a load needs 1 bubble when adjacent, 0 at distance two and 1 at distance three. The store's address register follows R2.
- R8: With every stage empty, stall, fwd_a, fwd_b and st_fwd are all 0.
- R9: A stall caused only by a producer that is older than MEM1 never occurs. An ALU result two or more instructions back never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_W | First source register of the ID instruction |
| id_rt | input | REG_W | Second source (or store data) register of the ID instruction |
| id_store | input | 1 | ID instruction is a store |
| ex1_rs | input | REG_W | First source register of the EX1 instruction |
| ex1_rt | input | REG_W | Second source register of the EX1 instruction |
| ex1_dst | input | REG_W | Destination register of the EX1 instruction |
| ex1_wr | input | 1 | EX1 instruction writes a register |
| ex2_dst | input | REG_W | Destination register of the EX2 instruction |
| ex2_wr | input | 1 | EX2 instruction writes a register |
| ex2_load | input | 1 | EX2 instruction is a load |
| mem1_dst | input | REG_W | Destination register of the MEM1 instruction |
| mem1_wr | input | 1 | MEM1 instruction writes a register |
| mem1_load | input | 1 | MEM1 instruction is a load |
| mem1_store | input | 1 | MEM1 instruction is a store |
| mem1_rt | input | REG_W | Store data register of the MEM1 instruction |
| mem2_dst | input | REG_W | Destination register of the MEM2 instruction |
| mem2_wr | input | 1 | MEM2 instruction writes a register |
| mem2_load | input | 1 | MEM2 instruction is a load |
| wb_dst | input | REG_W | Destination register of the WB instruction |
| wb_wr | input | 1 | WB instruction writes a register |
| stall | output | 1 | Hold IF/ID and bubble EX1 |
| fwd_a | output | 2 | Source select for the first EX1 operand |
| fwd_b | output | 2 | Source select for the second EX1 operand |
| st_fwd | output | 1 | Replace MEM1 store data with the MEM2/WB latch value |

## Verification
Every output is combinational, so each one is due in the same cycle as the stage contents that cause it. The bench drives the stage fields on the falling edge and samples one nanosecond later. At the rising edge it advances its own model of stage occupancy, using the stall it just observed. The bubble counts in R1, R2 and R7 therefore only become visible over the following cycles. They are checked by counting stall cycles across each short program once the pipeline has drained.

// File: rtl/hazard_split7.sv
module hazard_split7 #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_store,
  input  logic [REG_W-1:0] ex1_rs,
  input  logic [REG_W-1:0] ex1_rt,
  input  logic [REG_W-1:0] ex1_dst,
  input  logic             ex1_wr,
  input  logic [REG_W-1:0] ex2_dst,
  input  logic             ex2_wr,
  input  logic             ex2_load,
  input  logic [REG_W-1:0] mem1_dst,
  input  logic             mem1_wr,
  input  logic             mem1_load,
  input  logic             mem1_store,
  input  logic [REG_W-1:0] mem1_rt,
  input  logic [REG_W-1:0] mem2_dst,
  input  logic             mem2_wr,
  input  logic             mem2_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr,
  output logic             stall,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             st_fwd
);

  localparam logic [1:0] SRC_RF = 2'd0;
  localparam logic [1:0] SRC_M1 = 2'd1;
  localparam logic [1:0] SRC_M2 = 2'd2;
  localparam logic [1:0] SRC_WB = 2'd3;

  function automatic logic [1:0] pick(input logic [REG_W-1:0] s);
    if (s == '0)                            pick = SRC_RF;
    else if (mem1_wr && mem1_dst == s)      pick = mem1_load ? SRC_RF : SRC_M1;
    else if (mem2_wr && mem2_dst == s)      pick = mem2_load ? SRC_RF : SRC_M2;
    else if (wb_wr && wb_dst == s)          pick = SRC_WB;
    else                                    pick = SRC_RF;
  endfunction

  function automatic logic must_wait(input logic [REG_W-1:0] s, input logic late_use);
    if (s == '0)                            must_wait = 1'b0;
    else if (ex1_wr && ex1_dst == s)        must_wait = 1'b1;
    else if (ex2_wr && ex2_dst == s)        must_wait = ex2_load && !late_use;
    else if (mem1_wr && mem1_dst == s)      must_wait = mem1_load;
    else                                    must_wait = 1'b0;
  endfunction

  always_comb begin
    fwd_a = pick(ex1_rs);
    fwd_b = pick(ex1_rt);
    stall = must_wait(id_rs, 1'b0) | must_wait(id_rt, id_store);
  end

  assign st_fwd = mem1_store && (mem1_rt != '0) && wb_wr && (wb_dst == mem1_rt)
                  && !(mem2_wr && mem2_dst == mem1_rt);

  always_comb begin
    if (ex1_rs == '0) AST_ZERO_REG_QUIET: assert (fwd_a == SRC_RF); // R5
    if (fwd_a == SRC_M1) AST_M1_ALU_ONLY: assert (mem1_wr && !mem1_load && mem1_dst == ex1_rs); // R3
    if (fwd_b == SRC_WB) AST_WB_MATCH: assert (wb_wr && wb_dst == ex1_rt); // R4
    if (stall) AST_STALL_HAS_SOURCE: assert ((id_rs != '0) || (id_rt != '0)); // R1
    if (stall) AST_STALL_YOUNG_PRODUCER: assert (ex1_wr || ex2_load || mem1_load); // R9
    if (st_fwd) AST_STFWD_STORE_WB: assert (mem1_store && wb_wr); // R6
  end

endmodule

// File: tb/test_hazard_split7.sv
module test_hazard_split7;

  typedef struct {
    int kind;
    int rs;
    int rt;
    int rd;
  } instr_t;

  localparam int K_NONE = 0;
  localparam int K_ALU  = 1;
  localparam int K_LOAD = 2;
  localparam int K_ST   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [4:0] id_rs, id_rt, ex1_rs, ex1_rt, ex1_dst, ex2_dst, mem1_dst, mem1_rt, mem2_dst, wb_dst;
  logic id_store, ex1_wr, ex2_wr, ex2_load, mem1_wr, mem1_load, mem1_store, mem2_wr, mem2_load, wb_wr;
  logic stall, st_fwd;
  logic [1:0] fwd_a, fwd_b;

  hazard_split7 #(.REG_W(5)) i_hazard_split7 (
    .id_rs(id_rs), .id_rt(id_rt), .id_store(id_store),
    .ex1_rs(ex1_rs), .ex1_rt(ex1_rt), .ex1_dst(ex1_dst), .ex1_wr(ex1_wr),
    .ex2_dst(ex2_dst), .ex2_wr(ex2_wr), .ex2_load(ex2_load),
    .mem1_dst(mem1_dst), .mem1_wr(mem1_wr), .mem1_load(mem1_load),
    .mem1_store(mem1_store), .mem1_rt(mem1_rt),
    .mem2_dst(mem2_dst), .mem2_wr(mem2_wr), .mem2_load(mem2_load),
    .wb_dst(wb_dst), .wb_wr(wb_wr),
    .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b), .st_fwd(st_fwd)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  instr_t st [1:6];
  instr_t prog [$];

  function automatic instr_t mk(int k, int s, int t, int d);
    instr_t x;
    x.kind = k; x.rs = s; x.rt = t; x.rd = d;
    return x;
  endfunction

  function automatic bit writes(int i);
    return st[i].kind == K_ALU || st[i].kind == K_LOAD;
  endfunction

  function automatic int nearest(int s, int lo, int hi);
    for (int i = lo; i <= hi; i++)
      if (writes(i) && st[i].rd == s) return i;
    return -1;
  endfunction

  function automatic bit src_waits(int s, bit data_of_store);
    int p;
    bit ld;
    if (s == 0) return 0;
    p = nearest(s, 2, 5);
    if (p < 0) return 0;
    ld = st[p].kind == K_LOAD;
    if (p + 1 >= (ld ? 6 : 4)) return 0;
    if (data_of_store && ld && p + 3 == 6) return 0;
    return 1;
  endfunction

  function automatic bit exp_stall();
    if (st[1].kind == K_NONE) return 0;
    return src_waits(st[1].rs, 0) || src_waits(st[1].rt, st[1].kind == K_ST);
  endfunction

  function automatic int exp_sel(int s);
    int p;
    if (s == 0) return 0;
    p = nearest(s, 4, 6);
    if (p < 0) return 0;
    if (st[p].kind == K_LOAD && p < 6) return 0;
    return p - 3;
  endfunction

  function automatic bit exp_stfwd();
    if (st[4].kind != K_ST || st[4].rt == 0) return 0;
    return nearest(st[4].rt, 5, 6) == 6;
  endfunction

  task automatic drive();
    id_rs = 5'(st[1].rs); id_rt = 5'(st[1].rt); id_store = st[1].kind == K_ST;
    ex1_rs = 5'(st[2].rs); ex1_rt = 5'(st[2].rt); ex1_dst = 5'(st[2].rd); ex1_wr = writes(2);
    ex2_dst = 5'(st[3].rd); ex2_wr = writes(3); ex2_load = st[3].kind == K_LOAD;
    mem1_dst = 5'(st[4].rd); mem1_wr = writes(4); mem1_load = st[4].kind == K_LOAD;
    mem1_store = st[4].kind == K_ST; mem1_rt = 5'(st[4].rt);
    mem2_dst = 5'(st[5].rd); mem2_wr = writes(5); mem2_load = st[5].kind == K_LOAD;
    wb_dst = 5'(st[6].rd); wb_wr = writes(6);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit empty();
    for (int i = 1; i <= 6; i++) if (st[i].kind != K_NONE) return 0;
    return 1;
  endfunction

  task automatic clear();
    for (int i = 1; i <= 6; i++) st[i] = mk(K_NONE, 0, 0, 0);
  endtask

  task automatic run(string req, int exp_bubbles);
    int bubbles = 0;
    int guard = 0;
    clear();
    while ((prog.size() > 0 || !empty()) && guard < 200) begin
      @(negedge clk);
      drive();
      #1;
      check("R1 stall", int'(stall), int'(exp_stall()));
      check("R3 fwd_a", int'(fwd_a), exp_sel(st[2].rs));
      check("R4 fwd_b", int'(fwd_b), exp_sel(st[2].rt));
      check("R6 st_fwd", int'(st_fwd), int'(exp_stfwd()));
      if (stall) bubbles++;
      @(posedge clk);
      for (int i = 6; i >= 3; i--) st[i] = st[i-1];
      if (stall) st[2] = mk(K_NONE, 0, 0, 0);
      else begin
        st[2] = st[1];
        st[1] = (prog.size() > 0) ? prog.pop_front() : mk(K_NONE, 0, 0, 0);
      end
      guard++;
    end
    check(req, bubbles, exp_bubbles);
  endtask

  initial begin
    clear();
    drive();
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check("R8 stall", int'(stall), 0);
    check("R8 fwd_a", int'(fwd_a), 0);
    check("R8 fwd_b", int'(fwd_b), 0);
    check("R8 st_fwd", int'(st_fwd), 0);

    prog.push_back(mk(K_ALU, 3, 4, 1)); prog.push_back(mk(K_ALU, 1, 3, 2));
    run("R1 alu adjacent bubbles", 1);

    prog.push_back(mk(K_ALU, 3, 4, 1)); prog.push_back(mk(K_ALU, 6, 7, 8));
    prog.push_back(mk(K_ALU, 2, 1, 9));
    run("R9 alu distance two", 0);

    prog.push_back(mk(K_LOAD, 6, 0, 5)); prog.push_back(mk(K_ALU, 8, 5, 9));
    run("R2 load distance one", 3);

    prog.push_back(mk(K_LOAD, 6, 0, 5)); prog.push_back(mk(K_ALU, 2, 3, 7));
    prog.push_back(mk(K_ALU, 5, 3, 9));
    run("R2 load distance two", 2);

    prog.push_back(mk(K_LOAD, 6, 0, 5)); prog.push_back(mk(K_ALU, 2, 3, 7));
    prog.push_back(mk(K_ALU, 2, 3, 8)); prog.push_back(mk(K_ALU, 5, 5, 9));
    run("R2 load distance three", 1);

    prog.push_back(mk(K_LOAD, 6, 0, 5)); prog.push_back(mk(K_ALU, 2, 3, 7));
    prog.push_back(mk(K_ALU, 2, 3, 8)); prog.push_back(mk(K_ALU, 2, 3, 10));
    prog.push_back(mk(K_ALU, 9, 5, 11));
    run("R2 load distance four", 0);

    prog.push_back(mk(K_LOAD, 6, 0, 5)); prog.push_back(mk(K_ST, 12, 5, 0));
    run("R7 store data adjacent", 1);

    prog.push_back(mk(K_LOAD, 6, 0, 5)); prog.push_back(mk(K_ALU, 2, 3, 7));
    prog.push_back(mk(K_ST, 12, 5, 0));
    run("R7 store data distance two", 0);

    prog.push_back(mk(K_LOAD, 6, 0, 5)); prog.push_back(mk(K_ALU, 2, 3, 7));
    prog.push_back(mk(K_ALU, 2, 3, 8)); prog.push_back(mk(K_ST, 12, 5, 0));
    run("R7 store data distance three", 1);

    prog.push_back(mk(K_LOAD, 6, 0, 5)); prog.push_back(mk(K_ST, 5, 2, 0));
    run("R7 store address adjacent", 3);

    prog.push_back(mk(K_ALU, 3, 4, 0)); prog.push_back(mk(K_ALU, 0, 0, 9));
    prog.push_back(mk(K_LOAD, 6, 0, 0)); prog.push_back(mk(K_ALU, 0, 0, 10));
    run("R5 register zero", 0);

    prog.push_back(mk(K_ALU, 3, 5, 4)); prog.push_back(mk(K_ALU, 2, 3, 4));
    prog.push_back(mk(K_ALU, 2, 3, 7)); prog.push_back(mk(K_ALU, 4, 4, 8));
    prog.push_back(mk(K_ALU, 2, 4, 9));
    run("R4 youngest writer", 0);

    prog.push_back(mk(K_ALU, 3, 4, 2)); prog.push_back(mk(K_ALU, 2, 3, 7));
    prog.push_back(mk(K_LOAD, 6, 0, 5)); prog.push_back(mk(K_ALU, 9, 5, 9));
    prog.push_back(mk(K_ST, 12, 7, 0)); prog.push_back(mk(K_LOAD, 5, 0, 4));
    prog.push_back(mk(K_LOAD, 4, 0, 5)); prog.push_back(mk(K_ALU, 4, 2, 7));
    prog.push_back(mk(K_LOAD, 7, 0, 4)); prog.push_back(mk(K_ST, 12, 7, 0));
    prog.push_back(mk(K_ALU, 7, 4, 2));
    run("R3 mixed sequence", 10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule